// File: doc/BRIEF.md
# Regulator Enable Sequencer

This block decides when two on-chip low-dropout regulators and one external regulator switch on and off. It watches the device ON/OFF state and the enable and power-good flags of three switching converters. A 3-bit mode input picks one of eight orderings. In some orderings a regulator starts together with a converter. In others it waits for a converter's power-good, sometimes with a fixed delay on top. Two modes first raise an external-regulator enable pin and start regulator 2 one millisecond later. The last mode also uses a sleep pin to switch regulator 1 off and on while the device stays ON.

Each regulator enable is held back by a fixed 170 µs alignment delay. Because of this, a regulator and a converter that are told to start together ramp at the same moment. All delays come from a clock-frequency parameter given in kHz. Once the power-up ordering has finished, the sequencer hands the two enable bits over to software. From then on, a register write sets them directly until the device leaves the ON state.

Top module: `ldo_seq`

## Requirements
- R1: After reset, and in any cycle where `on_state` is low, `ldo1_en`, `ldo2_en` and `ext_en` are all low.
- R2: A regulator enable rises exactly ALIGN = 170·CLK_KHZ/1000 clock edges after its internal request becomes true, and falls with no delay when the request drops.
- R3: Mode 0 requests both regulators as soon as ON. Mode 1 requests both once converter 3 (index 2) is enabled and power-good. Mode 4 requests regulator 1 on converter 1 (index 0) power-good and regulator 2 with converter 3 enable. Mode 5 requests regulator 1 with converter 2 (index 1) enable and regulator 2 on converter 1 enable plus power-good.
- R4: Modes 2 and 7 drive `ext_en` high for the whole ON state, and only those modes do. Regulator 2 is requested 1 ms of clock edges after ON begins. In mode 2, regulator 1 is requested with converter 3 enable, and `ldo2_en` is never high without `ext_en`.
- R5: Mode 3 requests regulator 1 300 µs after converter 1 power-good. Regulator 2 is never requested by the hardware in this mode.
- R6: Mode 6 requests regulator 1 10 ms after converter 2 power-good. Regulator 2 is never requested by the hardware in this mode.
- R7: In mode 7, regulator 1 needs `sleep_in` high and converter 3 power-good. `ldo1_en` is low in every cycle where `sleep_in` is low, and it rises again ALIGN edges after `sleep_in` returns high.
- R8: A delay timer counts only while ON and while its trigger is high. If the trigger drops, the count clears, and a later trigger waits the full delay again.
- R9: When `on_state` falls, `ext_en`, `ldo2_en` and `ldo1_en` go low in that same cycle. The next power-up repeats the whole sequence with all its delays.
- R10: `sw_wr` loads `sw_en` (bit 0 = regulator 1, bit 1 = regulator 2) only after the power-up sequence is complete. Before that point it is ignored. A software disable of regulator 2 leaves `ext_en` high. A software enable still passes through the ALIGN delay.
- R11: Delay lengths in clock edges are 300·CLK_KHZ/1000, CLK_KHZ and 10·CLK_KHZ, for 300 µs, 1 ms and 10 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Sequencing mode, held stable while ON |
| on_state | input | 1 | Device is in the ON state |
| dc_en | input | 3 | Enables of converters 1..3 (bits 0..2) |
| dc_pg | input | 3 | Power-good of converters 1..3 (bits 0..2) |
| sleep_in | input | 1 | Sleep-control pin; low puts regulator 1 to sleep in mode 7 |
| sw_wr | input | 1 | Register write strobe for the enable bits |
| sw_en | input | 2 | Written enable bits: bit 0 regulator 1, bit 1 regulator 2 |
| ldo1_en | output | 1 | Regulator 1 enable |
| ldo2_en | output | 1 | Regulator 2 enable |
| ext_en | output | 1 | External-regulator enable pin |

## Verification
The bench sweeps all eight modes and measures the exact edge on which each output rises. This catches a timer that is one edge off, or an alignment delay that is missing or applied twice. It drops converter 1 power-good partway through the 300 µs wait. A timer that is not cleared on that drop would fire early. It pulses a register write during the 10 ms wait; a design that accepted the write early would light regulator 2. It turns power off in mode 2, where a registered pin would let `ext_en` lag `ldo2_en` by a cycle. It toggles the sleep pin in mode 7 and writes a software disable of regulator 2 in mode 2, where a wrong tie between the regulator-2 bit and the external pin would drop `ext_en`.

// File: rtl/ldo_seq.sv
module ldo_seq #(
  parameter int CLK_KHZ = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       on_state,
  input  logic [2:0] dc_en,
  input  logic [2:0] dc_pg,
  input  logic       sleep_in,
  input  logic       sw_wr,
  input  logic [1:0] sw_en,
  output logic       ldo1_en,
  output logic       ldo2_en,
  output logic       ext_en
);
  localparam int ALIGN = 170 * CLK_KHZ / 1000;
  localparam int T300  = 300 * CLK_KHZ / 1000;
  localparam int T1MS  = CLK_KHZ;
  localparam int T10MS = 10 * CLK_KHZ;
  localparam int TW    = $clog2(T10MS + 1);
  localparam int AW    = $clog2(ALIGN + 1);

  logic [TW-1:0] tcnt, tlim;
  logic          trg, tdone;
  logic [1:0]    cond, en_reg, req;
  logic          done, sw2_mode, ext_mode;

  assign sw2_mode = (mode == 3'd3) || (mode == 3'd6);
  assign ext_mode = (mode == 3'd2) || (mode == 3'd7);
  assign ext_en   = on_state && ext_mode;
  assign tdone    = (tcnt == tlim);

  always_comb begin
    trg  = 1'b0;
    tlim = TW'(T1MS);
    cond = 2'b00;
    case (mode)
      3'd0: cond = 2'b11;
      3'd1: cond = {2{dc_en[2] && dc_pg[2]}};
      3'd2: begin
        trg  = 1'b1;
        cond = {tdone, dc_en[2]};
      end
      3'd3: begin
        trg  = dc_pg[0];
        tlim = TW'(T300);
        cond = {1'b0, tdone && dc_pg[0]};
      end
      3'd4: cond = {dc_en[2], dc_pg[0]};
      3'd5: cond = {dc_en[0] && dc_pg[0], dc_en[1]};
      3'd6: begin
        trg  = dc_pg[1];
        tlim = TW'(T10MS);
        cond = {1'b0, tdone && dc_pg[1]};
      end
      default: begin
        trg  = 1'b1;
        cond = {tdone, sleep_in && dc_pg[2]};
      end
    endcase
    if (!on_state) cond = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (on_state && trg) begin
      if (!tdone) tcnt <= tcnt + 1'b1;
    end else begin
      tcnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      en_reg <= 2'b00;
    end else if (!on_state) begin
      done   <= 1'b0;
      en_reg <= 2'b00;
    end else if (!done) begin
      en_reg <= cond;
      done   <= cond[0] && (cond[1] || sw2_mode);
    end else if (sw_wr) begin
      en_reg <= sw_en;
    end
  end

  assign req[0] = on_state && (done ? en_reg[0] : cond[0]) &&
                  ((mode != 3'd7) || sleep_in);
  assign req[1] = on_state && (done ? en_reg[1] : cond[1]);

  logic [1:0] aligned;
  for (genvar i = 0; i < 2; i++) begin : g_align
    logic [AW-1:0] acnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       acnt <= '0;
      else if (!req[i])                 acnt <= '0;
      else if (acnt != AW'(ALIGN))      acnt <= acnt + 1'b1;
    end
    assign aligned[i] = req[i] && (acnt == AW'(ALIGN));
  end

  assign ldo1_en = aligned[0];
  assign ldo2_en = aligned[1];
endmodule

module ldo_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       on_state,
  input logic       sleep_in,
  input logic       ldo1_en,
  input logic       ldo2_en,
  input logic       ext_en
);
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !on_state |-> (!ldo1_en && !ldo2_en && !ext_en));

  assert_ext_modes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |-> (mode == 3'd2 || mode == 3'd7));

  assert_ldo2_needs_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && ldo2_en) |-> ext_en);

  assert_sleep_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7 && !sleep_in) |-> !ldo1_en);

  assert_rise_needs_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldo1_en) |-> ($past(on_state) && on_state));
endmodule

bind ldo_seq ldo_seq_chk u_chk (.*);

// File: tb/tb_ldo_seq.sv
module tb_ldo_seq;
  localparam int KHZ   = 100;
  localparam int ALIGN = 170 * KHZ / 1000;
  localparam int T300  = 300 * KHZ / 1000;
  localparam int T1MS  = KHZ;
  localparam int T10MS = 10 * KHZ;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0, dc_en = 0, dc_pg = 0;
  logic on_state = 0, sleep_in = 1, sw_wr = 0;
  logic [1:0] sw_en = 0;
  logic ldo1_en, ldo2_en, ext_en;
  int tests = 0, fails = 0, cyc = 0;

  ldo_seq #(.CLK_KHZ(KHZ)) dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); @(negedge clk); #1;
  endtask

  // First sample index (0 = right after stimulus) at which each output is high, -1 if never
  task automatic measure(int n, output int r1, output int r2, output int re);
    r1 = -1; r2 = -1; re = -1;
    #1;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) begin @(posedge clk); @(negedge clk); sw_wr = 0; #1; end
      if (ldo1_en && r1 < 0) r1 = k;
      if (ldo2_en && r2 < 0) r2 = k;
      if (ext_en  && re < 0) re = k;
    end
  endtask

  task automatic restart(logic [2:0] m);
    @(negedge clk);
    on_state = 0; sw_wr = 0; mode = m; dc_en = 3'b111; dc_pg = 3'b111; sleep_in = 1;
    edge1();
    @(negedge clk);
  endtask

  int r1, r2, re, e1, e2, ee;

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ldo1", ldo1_en, 0);
    chk("R1 reset ldo2", ldo2_en, 0);
    chk("R1 reset ext", ext_en, 0);
    @(negedge clk); rst_n = 1;

    // R3 R4 R5 R6 R7 R11 R2: full mode sweep, all converters up
    for (int m = 0; m < 8; m++) begin
      restart(3'(m));
      on_state = 1;
      measure(T10MS + ALIGN + 5, r1, r2, re);
      e1 = (m == 3) ? T300 + ALIGN : (m == 6) ? T10MS + ALIGN : ALIGN;
      e2 = (m == 3 || m == 6) ? -1 : (m == 2 || m == 7) ? T1MS + ALIGN : ALIGN;
      ee = (m == 2 || m == 7) ? 0 : -1;
      chk($sformatf("R3/R5/R6/R11 mode %0d ldo1 rise", m), r1, e1);
      chk($sformatf("R3/R4/R2 mode %0d ldo2 rise", m), r2, e2);
      chk($sformatf("R4 mode %0d ext rise", m), re, ee);
    end

    // R3: mode 1 gated by converter 3 power-good
    restart(3'd1); dc_pg = 3'b011; on_state = 1;
    measure(60, r1, r2, re);
    chk("R3 mode1 no pg ldo1", r1, -1);
    @(negedge clk); dc_pg = 3'b111;
    measure(40, r1, r2, re);
    chk("R3 mode1 after pg ldo1", r1, ALIGN);

    // R8: mode 3 timer clears on pg drop
    restart(3'd3); dc_pg = 3'b110; on_state = 1;
    repeat (5) edge1();
    @(negedge clk); dc_pg = 3'b111;
    repeat (20) edge1();
    @(negedge clk); dc_pg = 3'b110;
    edge1();
    @(negedge clk); dc_pg = 3'b111;
    measure(T300 + ALIGN + 10, r1, r2, re);
    chk("R8 mode3 timer restart", r1, T300 + ALIGN);

    // R10: write during 10 ms wait ignored, then accepted after completion
    restart(3'd6); on_state = 1;
    repeat (50) edge1();
    @(negedge clk); sw_en = 2'b11; sw_wr = 1;
    measure(60, r1, r2, re);
    chk("R10 early write ignored ldo2", r2, -1);
    repeat (T10MS) edge1();
    @(negedge clk); sw_en = 2'b11; sw_wr = 1;
    measure(40, r1, r2, re);
    chk("R10 sw enable ldo2 mode6", r2, ALIGN + 1);

    // R10 R9: mode 2 software ldo2 disable keeps ext, power-down drops together
    restart(3'd2); on_state = 1;
    repeat (T1MS + ALIGN + 5) edge1();
    @(negedge clk); sw_en = 2'b01; sw_wr = 1;
    edge1(); sw_wr = 0;
    chk("R10 sw disable ldo2", ldo2_en, 0);
    chk("R10 ext kept high", ext_en, 1);
    chk("R10 ldo1 kept", ldo1_en, 1);
    @(negedge clk); sw_en = 2'b11; sw_wr = 1;
    measure(40, r1, r2, re);
    chk("R10/R2 sw re-enable aligned", r2, ALIGN + 1);
    @(negedge clk); on_state = 0; #1;
    chk("R9 ext drops same cycle", ext_en, 0);
    chk("R9 ldo2 drops same cycle", ldo2_en, 0);
    chk("R9 ldo1 drops", ldo1_en, 0);
    edge1();
    @(negedge clk); on_state = 1;
    measure(T1MS + ALIGN + 5, r1, r2, re);
    chk("R9 full resequence ldo2", r2, T1MS + ALIGN);

    // R7: sleep pin in mode 7
    restart(3'd7); on_state = 1;
    repeat (T1MS + ALIGN + 5) edge1();
    @(negedge clk); sleep_in = 0; #1;
    chk("R7 sleep drops ldo1", ldo1_en, 0);
    chk("R7 sleep keeps ldo2", ldo2_en, 1);
    edge1();
    @(negedge clk); sleep_in = 1;
    measure(40, r1, r2, re);
    chk("R7 wake ldo1 aligned", r1, ALIGN);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule